// File: doc/BRIEF.md
# Virtual Memory Access Error Checker

This block sits beside the memory access path and inspects every access request. It checks whether the request is legal and records each kind of error as a sticky bit in a 32-bit status word. A request carries:

- the requester's source code;
- a read/write flag;
- the target region (control, packet or virtual);
- a 32-bit address;
- the bank mode (single or multi).

The block also receives the control, packet and virtual base registers and the packet memory offset value. From the buffer-mapping logic it takes a page-fault flag and the first 16 bits of the fetched map entry.

Any detected error can raise a lock output in the same cycle, if the matching bit of a lock-mask input is set. The memory controller uses this lock to freeze the failing access it has captured. Two further outputs report back to the requester:

- a read that faults while its lock is not armed completes, and is flagged as carrying invalid data;
- a write from a recoverable requester that faults returns a per-request failure pulse, so the requester can mark its packet failed or drop it.

Software reads the status word through a small register port. The port has a set address and a clear address. Both read back the same value. Writing ones at the set address forces bits on, and writing ones at the clear address clears bits.

Top module: `vm_access_checker`

## Requirements
- R1: Status bit 16 is set whenever the base values break the strict ordering control < packet < virtual, checked every cycle regardless of `req_valid`; equal values count as a violation.
- R2: A valid read to the virtual region (`req_region`=2'b10, `req_write`=0) with `map_fault`=1 sets bit 15. `rd_invalid` is high in that cycle exactly when `lock_mask[15]` is 0.
- R3: A valid control-region access (`req_region`=2'b00) sets bit 14 in these cases:
  - single-bank mode (`multi_bank`=0), when the address is greater than `pkt_offset`;
  - multi-bank mode, when any of address bits 31:27 is nonzero.
- R4: A valid packet-region access (`req_region`=2'b01) sets bit 13 in these cases:
  - any of address bits 31:27 is nonzero, in either mode;
  - the address is zero in single-bank mode.
- R5: A valid virtual-region access sets bit 12 when `map_word` differs from 16'h0656.
- R6: A valid virtual write with `map_fault`=1 from a source outside the recoverable class sets bit 11.
- R7: A valid virtual write with `map_fault`=1 from a recoverable source (codes 2 and 5 by default) sets bit 10 instead of bit 11, and pulses `recov_fail` in that cycle.
- R8: Bits 31:17 and 9:0 always read as zero. All status bits are zero after reset.
- R9: Status bits are sticky. A write with `reg_sel`=1 (clear address) clears the bits written as 1. A write with `reg_sel`=0 (set address) sets the implemented bits written as 1. An error detected in the same cycle as a clear leaves its bit set.
- R10: `lock_out[n]` is high in the cycle an error for status bit n is detected, exactly when `lock_mask[n]` is 1. The status bit then reads set from the next cycle.
- R11: The per-access checks (bits 15 to 10) and their lock, `rd_invalid` and `recov_fail` outputs stay inactive while `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 2 | 00 control, 01 packet, 10 virtual, 11 unchecked |
| req_src | input | 3 | Requester source code |
| req_addr | input | 32 | Access address |
| multi_bank | input | 1 | 1 = multi-bank mode, 0 = single-bank mode |
| ctl_base | input | 32 | Control base value |
| pkt_base | input | 32 | Packet base value |
| virt_base | input | 32 | Virtual base value |
| pkt_offset | input | 32 | Packet memory offset (upper bound for control in single-bank mode) |
| map_fault | input | 1 | No real buffer available for this virtual access |
| map_word | input | 16 | First 16 bits of the fetched map entry |
| lock_mask | input | 17 | Per-status-bit lock enable |
| lock_out | output | 17 | Per-status-bit lock request, same cycle as detection |
| rd_invalid | output | 1 | Faulting virtual read completes with invalid data |
| recov_fail | output | 1 | Recoverable write fault for the current request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = set address, 1 = clear address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Status word read data |

## Verification
On every cycle, the assertions check the following:
- a detected lock is followed by its status bit;
- a base-order violation always lands in bit 16;
- set bits never drop unless a clear wrote them;
- the recoverable and non-recoverable write-fault bits never fire together;
- the reserved bits stay zero.

Other behaviour can only be shown by the bench's scenarios, which drive chosen requests and compare the results with expected values. These are:
- the address-legality rules in each bank mode, including the exact boundary at the packet offset and address zero;
- the map signature check;
- which requester codes count as recoverable;
- the set and clear register behaviour, including an error that arrives in the same cycle as its clear.

// File: rtl/vmchk_pkg.sv
// Package: shared constants for the virtual memory access error checker.
// Assumes a 32-bit status word in which bits 16 down to 10 are implemented.
package vmchk_pkg;
    localparam int ADDR_W  = 32;
    localparam int REG_W   = 32;
    localparam int STAT_W  = 17;
    localparam int HI_BITS = 5;

    // Status bit positions: software decodes these, so they are fixed.
    localparam int B_BASE_ORDER = 16;
    localparam int B_RD_FAULT   = 15;
    localparam int B_CTL_RANGE  = 14;
    localparam int B_PKT_RANGE  = 13;
    localparam int B_BAD_MAP    = 12;
    localparam int B_WR_FATAL   = 11;
    localparam int B_WR_RECOV   = 10;

    localparam logic [REG_W-1:0] IMPL_MASK = 32'h0001_FC00;
    localparam logic [15:0]      MAP_SIG   = 16'h0656;

    typedef enum logic [1:0] {
        RGN_CTL  = 2'b00,
        RGN_PKT  = 2'b01,
        RGN_VIRT = 2'b10,
        RGN_NONE = 2'b11
    } region_e;
endpackage

// File: rtl/vmchk_detect.sv
// Module: vmchk_detect
// Combinational error detection for one access request per cycle.
// The base-ordering check runs every cycle; the per-access checks are
// gated by req_valid. The recoverable requester class is a bitmask
// indexed by the source code. Assumes the inputs are stable before the clock edge.
module vmchk_detect
    import vmchk_pkg::*;
#(
    parameter int SRC_W = 3,
    parameter logic [(1<<SRC_W)-1:0] RECOV_MASK = 8'b0010_0100
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_region,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              multi_bank,
    input  logic [ADDR_W-1:0] ctl_base,
    input  logic [ADDR_W-1:0] pkt_base,
    input  logic [ADDR_W-1:0] virt_base,
    input  logic [ADDR_W-1:0] pkt_offset,
    input  logic              map_fault,
    input  logic [15:0]       map_word,
    output logic [STAT_W-1:0] err_vec,
    output logic              rd_fault,
    output logic              wr_recov
);
    localparam int HI_LSB = ADDR_W - HI_BITS;

    logic is_ctl, is_pkt, is_virt, hi_nz, recov_src, wr_fault;

    // Purpose: decode region, requester class and the high-address test.
    always_comb begin
        is_ctl    = req_valid && (region_e'(req_region) == RGN_CTL);
        is_pkt    = req_valid && (region_e'(req_region) == RGN_PKT);
        is_virt   = req_valid && (region_e'(req_region) == RGN_VIRT);
        hi_nz     = |req_addr[ADDR_W-1:HI_LSB];
        recov_src = RECOV_MASK[req_src];
        wr_fault  = is_virt && req_write && map_fault;
    end

    // Purpose: form the per-bit error vector for this cycle.
    always_comb begin
        err_vec = '0;
        err_vec[B_BASE_ORDER] = !((ctl_base < pkt_base) && (pkt_base < virt_base));
        err_vec[B_RD_FAULT]   = is_virt && !req_write && map_fault;
        err_vec[B_CTL_RANGE]  = is_ctl && (multi_bank ? hi_nz : (req_addr > pkt_offset));
        err_vec[B_PKT_RANGE]  = is_pkt && (hi_nz || (!multi_bank && (req_addr == '0)));
        err_vec[B_BAD_MAP]    = is_virt && (map_word != MAP_SIG);
        err_vec[B_WR_FATAL]   = wr_fault && !recov_src;
        err_vec[B_WR_RECOV]   = wr_fault && recov_src;
        rd_fault = err_vec[B_RD_FAULT];
        wr_recov = err_vec[B_WR_RECOV];
    end

    // Purpose: the two write-fault classes exclude each other (R6, R7).
    always_comb begin
        assert_wr_class_excl_R7: assert (!(err_vec[B_WR_FATAL] && err_vec[B_WR_RECOV]))
            else $error("both write fault classes active");
    end
endmodule

// File: rtl/vmchk_status.sv
// Module: vmchk_status
// Sticky status register with separate set and clear write addresses.
// A hardware error wins over a software clear in the same cycle.
// Only the bits in IMPL_MASK are stored; the others read as zero.
module vmchk_status
    import vmchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] err_vec,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  status_q
);
    logic [REG_W-1:0] set_vec, clr_vec, hw_vec, status_d;

    // Purpose: split the register write into set and clear vectors.
    always_comb begin
        set_vec  = (reg_wr && !reg_sel) ? reg_wdata : '0;
        clr_vec  = (reg_wr &&  reg_sel) ? reg_wdata : '0;
        hw_vec   = REG_W'(err_vec);
        status_d = (((status_q | set_vec) & ~clr_vec) | hw_vec) & IMPL_MASK;
    end

    // Purpose: hold the sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // A set bit drops only when the clear address wrote a one to it (R9).
    property p_sticky;
        @(posedge clk) disable iff (!rst_n)
        1 |=> (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0);
    endproperty
    assert_sticky_R9: assert property (p_sticky) else $error("status bit lost");

    // Reserved and unimplemented bits stay zero (R8).
    property p_reserved;
        @(posedge clk) disable iff (!rst_n)
        1 |=> ((status_q & ~IMPL_MASK) == '0);
    endproperty
    assert_reserved_zero_R8: assert property (p_reserved) else $error("reserved bit set");
endmodule

// File: rtl/vm_access_checker.sv
// Module: vm_access_checker (top)
// Watches memory access requests and base values, records errors as sticky
// status bits, raises per-bit lock requests enabled by lock_mask in the
// detection cycle, and returns per-request invalid-read and recoverable
// write-failure flags. Assumes one request per cycle.
module vm_access_checker
    import vmchk_pkg::*;
#(
    parameter int SRC_W = 3,
    parameter logic [(1<<SRC_W)-1:0] RECOV_MASK = 8'b0010_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_region,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [31:0]       req_addr,
    input  logic              multi_bank,
    input  logic [31:0]       ctl_base,
    input  logic [31:0]       pkt_base,
    input  logic [31:0]       virt_base,
    input  logic [31:0]       pkt_offset,
    input  logic              map_fault,
    input  logic [15:0]       map_word,
    input  logic [16:0]       lock_mask,
    output logic [16:0]       lock_out,
    output logic              rd_invalid,
    output logic              recov_fail,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    logic [STAT_W-1:0] err_vec;
    logic [REG_W-1:0]  status_q;
    logic              rd_fault, wr_recov;

    vmchk_detect #(.SRC_W(SRC_W), .RECOV_MASK(RECOV_MASK)) u_detect (
        .req_valid (req_valid),  .req_write (req_write),
        .req_region(req_region), .req_src   (req_src),
        .req_addr  (req_addr),   .multi_bank(multi_bank),
        .ctl_base  (ctl_base),   .pkt_base  (pkt_base),
        .virt_base (virt_base),  .pkt_offset(pkt_offset),
        .map_fault (map_fault),  .map_word  (map_word),
        .err_vec   (err_vec),    .rd_fault  (rd_fault),
        .wr_recov  (wr_recov)
    );

    vmchk_status u_status (
        .clk      (clk),      .rst_n    (rst_n),
        .err_vec  (err_vec),  .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),  .reg_wdata(reg_wdata),
        .status_q (status_q)
    );

    // Purpose: drive lock requests, requester flags and read data.
    always_comb begin
        lock_out   = err_vec & lock_mask;
        rd_invalid = rd_fault && !lock_mask[B_RD_FAULT];
        recov_fail = wr_recov;
        reg_rdata  = status_q;
    end

    // Each lock request is followed by its status bit (R10).
    property p_lock_follows;
        @(posedge clk) disable iff (!rst_n)
        (|lock_out) |=> ((status_q[STAT_W-1:0] & $past(lock_out)) == $past(lock_out));
    endproperty
    assert_lock_recorded_R10: assert property (p_lock_follows) else $error("lock without status");

    // A base ordering violation always lands in bit 16 (R1).
    property p_base_order;
        @(posedge clk) disable iff (!rst_n)
        !((ctl_base < pkt_base) && (pkt_base < virt_base)) |=> status_q[B_BASE_ORDER];
    endproperty
    assert_base_order_R1: assert property (p_base_order) else $error("order violation missed");

    // A recoverable failure pulse is recorded in bit 10 (R7).
    property p_recov_recorded;
        @(posedge clk) disable iff (!rst_n)
        recov_fail |=> status_q[B_WR_RECOV];
    endproperty
    assert_recov_recorded_R7: assert property (p_recov_recorded) else $error("recov not recorded");

    // Invalid-read flag and read lock never coexist; both need a request (R2, R11).
    property p_rdinv;
        @(posedge clk) disable iff (!rst_n)
        rd_invalid |-> (!lock_out[B_RD_FAULT] && req_valid);
    endproperty
    assert_rd_invalid_R2: assert property (p_rdinv) else $error("rd_invalid with lock");
endmodule

// File: tb/vm_access_checker_test.sv
// Bench for vm_access_checker: a table of request vectors walked by one loop,
// then directed tests for reset, base ordering, set/clear and stickiness.
module vm_access_checker_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, multi_bank = 0, map_fault = 0;
    logic [1:0]  req_region = 0;
    logic [2:0]  req_src = 0;
    logic [31:0] req_addr = 0;
    logic [31:0] ctl_base = 32'h1000, pkt_base = 32'h2000, virt_base = 32'h3000;
    logic [31:0] pkt_offset = 32'h0010_0000;
    logic [15:0] map_word = 16'h0656;
    logic [16:0] lock_mask = 0, lock_out;
    logic rd_invalid, recov_fail, reg_wr = 0, reg_sel = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vm_access_checker uut (.*);

    typedef struct packed {
        logic        v;
        logic        wr;
        logic [1:0]  rg;
        logic [2:0]  src;
        logic [31:0] addr;
        logic        multi;
        logic        fault;
        logic [15:0] mapw;
        logic [16:0] mask;
        logic [16:0] est;
        logic [16:0] elk;
        logic        einv;
        logic        ercv;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // R3 boundary: control address equal to offset is legal in single-bank mode
        '{1'b1,1'b0,2'b00,3'd0,32'h0010_0000,1'b0,1'b0,16'h0656,17'h0,     17'h0,     17'h0,     1'b0,1'b0},
        '{1'b1,1'b0,2'b00,3'd0,32'h0010_0001,1'b0,1'b0,16'h0656,17'h04000,17'h04000,17'h04000,1'b0,1'b0},
        '{1'b1,1'b1,2'b00,3'd0,32'h0010_0001,1'b1,1'b0,16'h0656,17'h0,     17'h0,     17'h0,     1'b0,1'b0},
        '{1'b1,1'b0,2'b00,3'd0,32'h0800_0000,1'b1,1'b0,16'h0656,17'h0,     17'h04000,17'h0,     1'b0,1'b0},
        // R4 packet range
        '{1'b1,1'b0,2'b01,3'd0,32'h0000_0000,1'b0,1'b0,16'h0656,17'h0,     17'h02000,17'h0,     1'b0,1'b0},
        '{1'b1,1'b0,2'b01,3'd0,32'h0000_0000,1'b1,1'b0,16'h0656,17'h0,     17'h0,     17'h0,     1'b0,1'b0},
        '{1'b1,1'b1,2'b01,3'd0,32'hF800_0000,1'b1,1'b0,16'h0656,17'h02000,17'h02000,17'h02000,1'b0,1'b0},
        '{1'b1,1'b0,2'b01,3'd0,32'h0000_0010,1'b0,1'b0,16'h0656,17'h0,     17'h0,     17'h0,     1'b0,1'b0},
        // R2 read page fault with and without lock
        '{1'b1,1'b0,2'b10,3'd2,32'h0000_0100,1'b0,1'b1,16'h0656,17'h0,     17'h08000,17'h0,     1'b1,1'b0},
        '{1'b1,1'b0,2'b10,3'd0,32'h0000_0100,1'b0,1'b1,16'h0656,17'h08000,17'h08000,17'h08000,1'b0,1'b0},
        // R6, R7 write faults by class
        '{1'b1,1'b1,2'b10,3'd0,32'h0000_0100,1'b0,1'b1,16'h0656,17'h00800,17'h00800,17'h00800,1'b0,1'b0},
        '{1'b1,1'b1,2'b10,3'd2,32'h0000_0100,1'b0,1'b1,16'h0656,17'h0,     17'h00400,17'h0,     1'b0,1'b1},
        '{1'b1,1'b1,2'b10,3'd5,32'h0000_0100,1'b1,1'b1,16'h0656,17'h00400,17'h00400,17'h00400,1'b0,1'b1},
        // R5 map signature
        '{1'b1,1'b0,2'b10,3'd0,32'h0000_0100,1'b0,1'b0,16'h0657,17'h01000,17'h01000,17'h01000,1'b0,1'b0},
        // R11 no request: nothing recorded
        '{1'b0,1'b1,2'b10,3'd2,32'hF800_0000,1'b0,1'b1,16'h0000,17'h1FFFF,17'h0,     17'h0,     1'b0,1'b0},
        '{1'b1,1'b1,2'b10,3'd2,32'h0000_0100,1'b0,1'b1,16'h1234,17'h0,     17'h01400,17'h0,     1'b0,1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic idle_req;
        req_valid = 0; map_fault = 0; map_word = 16'h0656; lock_mask = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset status", reg_rdata, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R8 idle after reset", reg_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = VECS[i].v; req_write = VECS[i].wr; req_region = VECS[i].rg;
            req_src = VECS[i].src; req_addr = VECS[i].addr; multi_bank = VECS[i].multi;
            map_fault = VECS[i].fault; map_word = VECS[i].mapw; lock_mask = VECS[i].mask;
            #1;
            chk($sformatf("R10 lock vec%0d", i), 32'(lock_out), 32'(VECS[i].elk));
            chk($sformatf("R2 rd_invalid vec%0d", i), 32'(rd_invalid), 32'(VECS[i].einv));
            chk($sformatf("R7 recov_fail vec%0d", i), 32'(recov_fail), 32'(VECS[i].ercv));
            @(negedge clk);
            idle_req();
            chk($sformatf("R11 status vec%0d", i), reg_rdata, 32'(VECS[i].est));
            reg_write(1'b1, 32'hFFFF_FFFF);
        end

        // R9 stickiness: error stays recorded through idle cycles
        @(negedge clk);
        req_valid = 1; req_region = 2'b00; multi_bank = 0; req_addr = 32'h0020_0000;
        @(negedge clk);
        idle_req();
        repeat (4) @(negedge clk);
        chk("R9 sticky bit14", reg_rdata, 32'h0000_4000);

        // R9 / R8 set address forces implemented bits only
        reg_write(1'b0, 32'hFFFF_FFFF);
        chk("R8 set all reads implemented bits", reg_rdata, 32'h0001_FC00);
        reg_write(1'b1, 32'h0000_4000);
        chk("R9 clear one bit", reg_rdata, 32'h0001_BC00);

        // R9 hardware error wins over a same-cycle clear
        @(negedge clk);
        reg_wr = 1; reg_sel = 1; reg_wdata = 32'hFFFF_FFFF;
        req_valid = 1; req_region = 2'b01; multi_bank = 0; req_addr = 32'h0;
        @(negedge clk);
        reg_wr = 0; idle_req();
        chk("R9 error beats clear", reg_rdata, 32'h0000_2000);
        reg_write(1'b1, 32'hFFFF_FFFF);
        chk("R9 clear all", reg_rdata, 32'h0);

        // R1 base ordering: equal values, then reversed, without any request
        @(negedge clk);
        pkt_base = 32'h3000; lock_mask = 17'h10000;
        #1;
        chk("R1 lock on equal bases", 32'(lock_out), 32'h0001_0000);
        @(negedge clk);
        chk("R1 equal bases", reg_rdata, 32'h0001_0000);
        pkt_base = 32'h2000; lock_mask = '0;
        reg_write(1'b1, 32'hFFFF_FFFF);
        chk("R1 clear after ordering restored", reg_rdata, 32'h0);
        @(negedge clk);
        ctl_base = 32'h2500;
        @(negedge clk);
        ctl_base = 32'h1000;
        chk("R1 control above packet", reg_rdata, 32'h0001_0000);
        reg_write(1'b1, 32'hFFFF_FFFF);

        // R8 reset mid-run clears status
        reg_write(1'b0, 32'h0000_0C00);
        chk("R8 set before reset", reg_rdata, 32'h0000_0C00);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R8 reset clears status", reg_rdata, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule